// File: doc/BRIEF.md
# Per-Channel C/I Change Monitor

This block sits on the upstream and downstream byte streams of a time-division frame. The frame carries two timeslots per channel. The even timeslot belongs to the monitor channel and is not handled here. The odd timeslot holds a D-channel pair, a 4-bit command/indicate (C/I) field and two handshake bits. For every channel the block stores the C/I value it last received. When a channel reports a value in one frame that differs from the value it reported in the frame before, the block queues that channel's odd-timeslot address in a 16-entry event FIFO. The interrupt stays raised for as long as the FIFO holds any address.

A host pops queued addresses and reads any channel's stored C/I value through a combinational read port. It also writes the C/I value that goes out downstream for each channel, which it uses to drive layer-1 devices. Downstream, the block builds the odd timeslot byte. The D-channel positions are left undriven, with their output enable held low. Both handshake positions are driven high, which is the behaviour without the handshake protocol. Upstream D-channel and handshake bits never affect the block.

Top module: `ci_change_mon`

## Requirements
- R1: In an odd timeslot byte, bit 7 is the most significant bit. The C/I field is bits [5:2]. The D-channel bits [7:6], the handshake bits [1:0] and every even-timeslot byte are ignored upstream.
- R2: After reset every stored upstream C/I value and every downstream C/I value reads 4'b1111. The first odd byte a channel receives after reset only stores its value and never queues an event.
- R3: A channel whose C/I value differs from the value it had in the previous frame queues its odd-timeslot address, 2*channel+1. Addresses leave the FIFO in the order they were detected.
- R4: A channel whose C/I value is the same as in the previous frame queues nothing, even when its D-channel or handshake bits have changed.
- R5: irq_o is high exactly while the event FIFO is not empty. evt_addr_o shows the oldest queued address, and pop_i removes it.
- R6: When 16 addresses are queued and no pop occurs, a new event is dropped and ovf_o is set. ovf_o stays set until reset.
- R7: A pop and a push in the same cycle both take effect, including when the FIFO is full. In that case no event is lost and ovf_o does not change.
- R8: dn_valid_o pulses one cycle after each accepted upstream strobe. For an odd timeslot, dn_byte_o = {2'b00, downstream C/I, 2'b11} and dn_oe_o = 8'h3F. For an even timeslot, dn_byte_o = 8'h00 and dn_oe_o = 8'h00.
- R9: wr_en_i stores wr_ci_i as the downstream C/I value of channel wr_ch_i, and that value is used from the next cycle on. rd_ci_o shows the stored upstream value of channel rd_ch_i.
- R10: A strobe with up_sync_i high is timeslot 0. Later strobes count up and wrap after the last timeslot. Strobes that arrive before the first sync after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| up_valid_i | input | 1 | Upstream byte strobe, one per timeslot |
| up_sync_i | input | 1 | Marks the strobed byte as timeslot 0 |
| up_byte_i | input | 8 | Upstream timeslot byte |
| dn_valid_o | output | 1 | Downstream byte valid |
| dn_byte_o | output | 8 | Downstream timeslot byte |
| dn_oe_o | output | 8 | Per-bit output enable for dn_byte_o |
| pop_i | input | 1 | Remove the oldest queued address |
| evt_addr_o | output | SLOT_W | Oldest queued timeslot address |
| irq_o | output | 1 | High while the event FIFO is not empty |
| ovf_o | output | 1 | Sticky flag: an event was dropped |
| rd_ch_i | input | CH_W | Channel selected for reading |
| rd_ci_o | output | 4 | Stored upstream C/I of rd_ch_i |
| wr_en_i | input | 1 | Write a downstream C/I value |
| wr_ch_i | input | CH_W | Channel to write |
| wr_ci_i | input | 4 | Downstream C/I value to write |

## Verification
The assertions check, on every cycle, the shape of the downstream byte and its output enable, that a downstream byte always follows an upstream strobe, that the interrupt rises only after a strobe and holds while nothing pops, and that the overflow flag rises only on an unpopped strobe and then stays set. Only the bench scenarios can show the per-channel comparison across frames: the silent first frame, changes hidden in the D-channel or handshake bits, the order of queued addresses, a pop and a push in the same cycle, dropping at full depth, ignoring strobes before the first sync, and re-synchronising in the middle of a frame.

// File: rtl/ci_mon_pkg.sv
package ci_mon_pkg;
  typedef struct packed {
    logic [1:0] d;
    logic [3:0] ci;
    logic       mr;
    logic       mx;
  } odd_slot_t;

  localparam logic [3:0] CI_RST = 4'b1111;
endpackage

// File: rtl/ci_slot_trk.sv
module ci_slot_trk #(
  parameter  int SLOTS  = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              sync_i,
  output logic              act_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

  logic              synced_q;
  logic [SLOT_W-1:0] cnt_q;

  assign slot_o = sync_i ? '0 : cnt_q;
  assign act_o  = valid_i & (sync_i | synced_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synced_q <= 1'b0;
      cnt_q    <= '0;
    end else if (act_o) begin
      synced_q <= 1'b1;
      cnt_q    <= (slot_o == LAST) ? '0 : slot_o + 1'b1;
    end
  end
endmodule

// File: rtl/ci_store.sv
module ci_store #(
  parameter  int N_CH = 8,
  localparam int CH_W = $clog2(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            odd_act_i,
  input  logic [CH_W-1:0] ch_i,
  input  logic [3:0]      ci_i,
  input  logic            wr_en_i,
  input  logic [CH_W-1:0] wr_ch_i,
  input  logic [3:0]      wr_ci_i,
  input  logic [CH_W-1:0] rd_ch_i,
  output logic            chg_o,
  output logic [3:0]      rd_ci_o,
  output logic [3:0]      dn_ci_o
);
  import ci_mon_pkg::*;

  logic [3:0]      up_q [N_CH];
  logic [3:0]      dn_q [N_CH];
  logic [N_CH-1:0] seen_q;

  // first sample of a channel only seeds the comparison
  assign chg_o   = odd_act_i & seen_q[ch_i] & (ci_i != up_q[ch_i]);
  assign rd_ci_o = up_q[rd_ch_i];
  assign dn_ci_o = dn_q[ch_i];

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        up_q[c]   <= CI_RST;
        dn_q[c]   <= CI_RST;
        seen_q[c] <= 1'b0;
      end else begin
        if (odd_act_i && ch_i == CH_W'(c)) begin
          up_q[c]   <= ci_i;
          seen_q[c] <= 1'b1;
        end
        if (wr_en_i && wr_ch_i == CH_W'(c)) dn_q[c] <= wr_ci_i;
      end
    end
  end
endmodule

// File: rtl/ci_evt_fifo.sv
module ci_evt_fifo #(
  parameter  int W     = 4,
  parameter  int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_pop  = pop_i & ~empty_o;
  assign do_push = push_i & (~full_o | do_pop);
  assign data_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wp_q] <= data_i;
        wp_q        <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      end
      if (do_pop) rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/ci_change_mon.sv
module ci_change_mon #(
  parameter  int N_CH       = 8,
  parameter  int FIFO_DEPTH = 16,
  localparam int SLOTS      = 2 * N_CH,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int CH_W       = $clog2(N_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              up_valid_i,
  input  logic              up_sync_i,
  input  logic [7:0]        up_byte_i,
  output logic              dn_valid_o,
  output logic [7:0]        dn_byte_o,
  output logic [7:0]        dn_oe_o,
  input  logic              pop_i,
  output logic [SLOT_W-1:0] evt_addr_o,
  output logic              irq_o,
  output logic              ovf_o,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [3:0]        rd_ci_o,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [3:0]        wr_ci_i
);
  import ci_mon_pkg::*;

  logic              act, odd_act, chg, f_empty, f_full;
  logic [SLOT_W-1:0] slot;
  logic [CH_W-1:0]   ch;
  logic [3:0]        dn_ci;
  odd_slot_t         up_s;
  logic              unused_bits;

  assign up_s        = up_byte_i;
  assign unused_bits = ^{up_s.d, up_s.mr, up_s.mx};

  ci_slot_trk #(.SLOTS(SLOTS)) u_trk (
    .clk_i, .rst_ni,
    .valid_i(up_valid_i), .sync_i(up_sync_i),
    .act_o(act), .slot_o(slot)
  );

  assign ch      = slot[SLOT_W-1:1];
  assign odd_act = act & slot[0];

  ci_store #(.N_CH(N_CH)) u_store (
    .clk_i, .rst_ni,
    .odd_act_i(odd_act), .ch_i(ch), .ci_i(up_s.ci),
    .wr_en_i, .wr_ch_i, .wr_ci_i,
    .rd_ch_i, .chg_o(chg), .rd_ci_o, .dn_ci_o(dn_ci)
  );

  ci_evt_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(chg), .data_i(slot), .pop_i,
    .data_o(evt_addr_o), .empty_o(f_empty), .full_o(f_full)
  );

  assign irq_o = ~f_empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_o      <= 1'b0;
      dn_valid_o <= 1'b0;
      dn_byte_o  <= '0;
      dn_oe_o    <= '0;
    end else begin
      if (chg && f_full && !pop_i) ovf_o <= 1'b1;
      dn_valid_o <= act;
      if (odd_act) begin
        // D pair tri-stated, handshake bits forced high
        dn_byte_o <= {2'b00, dn_ci, 2'b11};
        dn_oe_o   <= 8'h3F;
      end else begin
        dn_byte_o <= '0;
        dn_oe_o   <= '0;
      end
    end
  end
endmodule

// File: rtl/ci_change_mon_chk.sv
module ci_change_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       up_valid_i,
  input logic       pop_i,
  input logic       irq_o,
  input logic       ovf_o,
  input logic       dn_valid_o,
  input logic [7:0] dn_byte_o,
  input logic [7:0] dn_oe_o
);
  // R8
  dn_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dn_valid_o |-> (dn_oe_o == 8'h00 && dn_byte_o == 8'h00) ||
                   (dn_oe_o == 8'h3F && dn_byte_o[1:0] == 2'b11 && dn_byte_o[7:6] == 2'b00));

  // R8
  dn_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dn_valid_o |-> dn_oe_o == 8'h00);

  // R8
  dn_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dn_valid_o) |-> $past(up_valid_i));

  // R5
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(up_valid_i));

  // R5
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !pop_i |=> irq_o);

  // R6
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  // R7
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(up_valid_i && !pop_i && irq_o));
endmodule

bind ci_change_mon ci_change_mon_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .up_valid_i(up_valid_i), .pop_i(pop_i),
  .irq_o(irq_o), .ovf_o(ovf_o), .dn_valid_o(dn_valid_o),
  .dn_byte_o(dn_byte_o), .dn_oe_o(dn_oe_o)
);

// File: tb/ci_change_mon_test.sv
module ci_change_mon_test;
  localparam int CLK_P = 10;
  localparam int NCH   = 8;
  localparam int NSL   = 2 * NCH;
  localparam int DEP   = 16;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_valid, up_sync, pop, wr_en;
  logic [7:0] up_byte;
  logic [2:0] rd_ch, wr_ch;
  logic [3:0] wr_ci;
  logic       dn_valid, irq, ovf;
  logic [7:0] dn_byte, dn_oe;
  logic [3:0] evt_addr, rd_ci;

  always #(CLK_P / 2) clk = ~clk;

  ci_change_mon #(.N_CH(NCH), .FIFO_DEPTH(DEP)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .up_valid_i(up_valid), .up_sync_i(up_sync), .up_byte_i(up_byte),
    .dn_valid_o(dn_valid), .dn_byte_o(dn_byte), .dn_oe_o(dn_oe),
    .pop_i(pop), .evt_addr_o(evt_addr), .irq_o(irq), .ovf_o(ovf),
    .rd_ch_i(rd_ch), .rd_ci_o(rd_ci),
    .wr_en_i(wr_en), .wr_ch_i(wr_ch), .wr_ci_i(wr_ci)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // scoreboard model
  int   exp_q[$];
  logic [3:0] prev_m[NCH];
  logic [3:0] dn_m[NCH];
  bit   seen_m[NCH];
  bit   synced_m;
  int   cnt_m;
  bit   ovf_m;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    up_valid = 0; up_sync = 0; up_byte = 0; pop = 0; wr_en = 0;
  endtask

  // one cycle: called and returns at a negedge
  task automatic step(input bit v, input bit s, input logic [7:0] b, input bit p);
    bit act, odd;
    int slot, ch;
    logic [7:0] xb, xo;
    if (p) begin
      // R5 / R7: head shown before the pop takes effect
      if (exp_q.size() > 0) begin
        chk(irq === 1'b1, "R5 irq before pop", int'(irq), 1);
        chk(int'(evt_addr) == exp_q[0], "R3 popped address", int'(evt_addr), exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
    up_valid = v; up_sync = s; up_byte = b; pop = p;
    act  = v && (s || synced_m);
    slot = s ? 0 : cnt_m;
    odd  = slot[0];
    ch   = slot / 2;
    xb = 8'h00; xo = 8'h00;
    if (act) begin
      synced_m = 1;
      cnt_m = (slot == NSL - 1) ? 0 : slot + 1;
      if (odd) begin
        xb = {2'b00, dn_m[ch], 2'b11};
        xo = 8'h3F;
        if (seen_m[ch] && b[5:2] != prev_m[ch]) begin
          if (exp_q.size() < DEP) exp_q.push_back(slot);
          else ovf_m = 1;
        end
        prev_m[ch] = b[5:2];
        seen_m[ch] = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    // R8 / R10
    chk(dn_valid === act, "R10 dn_valid follows accepted strobe", int'(dn_valid), int'(act));
    if (act) begin
      chk(dn_byte === xb, "R8 dn_byte", int'(dn_byte), int'(xb));
      chk(dn_oe === xo, "R8 dn_oe", int'(dn_oe), int'(xo));
    end
    chk(irq === (exp_q.size() != 0), "R5 irq level", int'(irq), int'(exp_q.size() != 0));
    chk(ovf === ovf_m, "R6 ovf flag", int'(ovf), int'(ovf_m));
    idle_inputs();
  endtask

  // whole frame; noise varies D and handshake bits (R1)
  task automatic frame(input logic [3:0] ci[NCH], input int noise, input int pop_slot);
    for (int s = 0; s < NSL; s++) begin
      logic [7:0] b;
      logic [1:0] nz;
      nz = 2'(noise + s);
      if (s % 2 == 1) b = {nz, ci[s / 2], ~nz};
      else b = 8'(8'hA5 ^ (s * 7) ^ noise);
      step(1, s == 0, b, s == pop_slot);
    end
  endtask

  task automatic drain();
    while (exp_q.size() > 0) step(0, 0, 8'h00, 1);
    chk(irq === 1'b0, "R5 irq low when drained", int'(irq), 0);
  endtask

  task automatic host_wr(input int c, input logic [3:0] v);
    wr_en = 1; wr_ch = 3'(c); wr_ci = v;
    @(posedge clk);
    @(negedge clk);
    dn_m[c] = v;
    wr_en = 0;
  endtask

  task automatic check_rd(input int c, input logic [3:0] v, input string req);
    rd_ch = 3'(c);
    #1;
    chk(rd_ci === v, req, int'(rd_ci), int'(v));
  endtask

  initial begin
    logic [3:0] f[NCH];
    idle_inputs();
    rd_ch = 0; wr_ch = 0; wr_ci = 0;
    rst_n = 0;
    synced_m = 0; cnt_m = 0; ovf_m = 0;
    for (int c = 0; c < NCH; c++) begin
      prev_m[c] = 4'hF; dn_m[c] = 4'hF; seen_m[c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R2 reset state
    chk(irq === 1'b0, "R2 irq after reset", int'(irq), 0);
    chk(ovf === 1'b0, "R2 ovf after reset", int'(ovf), 0);
    chk(dn_valid === 1'b0, "R2 dn_valid after reset", int'(dn_valid), 0);
    for (int c = 0; c < NCH; c++) check_rd(c, 4'hF, "R2 stored C/I after reset");

    // R10: strobes before first sync are ignored
    for (int i = 0; i < 5; i++) step(1, 0, 8'b00_0000_00, 0);
    for (int c = 0; c < 3; c++) check_rd(c, 4'hF, "R10 pre-sync strobe ignored");

    // R2: seeding frame reports nothing
    for (int c = 0; c < NCH; c++) f[c] = 4'(c);
    frame(f, 0, -1);
    chk(irq === 1'b0, "R2 first frame silent", int'(irq), 0);
    for (int c = 0; c < NCH; c++) check_rd(c, 4'(c), "R1 R9 stored C/I read back");

    // R4 / R1: same C/I, different D and handshake bits
    frame(f, 3, -1);
    chk(irq === 1'b0, "R4 no change no event", int'(irq), 0);

    // R3: two changes, ordered
    f[2] = 4'hC; f[5] = 4'h3;
    frame(f, 1, -1);
    chk(exp_q.size() == 2, "R3 two events queued", exp_q.size(), 2);
    drain();

    // R7: pop and push in the same cycle
    f[1] = 4'h9; f[3] = 4'hE;
    frame(f, 2, -1);
    f[4] = 4'h0;
    frame(f, 0, 9);
    drain();

    // R9 / R8: host downstream write
    host_wr(6, 4'hA);
    host_wr(0, 4'h5);
    frame(f, 1, -1);

    // R6 / R7: fill, overflow, full pop+push
    for (int c = 0; c < NCH; c++) f[c] = ~f[c];
    frame(f, 0, -1);
    for (int c = 0; c < NCH; c++) f[c] = ~f[c];
    frame(f, 2, -1);
    chk(exp_q.size() == DEP, "R6 fifo full", exp_q.size(), DEP);
    f[0] = f[0] + 4'h1;
    f[7] = f[7] + 4'h1;
    frame(f, 1, 15);
    chk(ovf === 1'b1, "R6 overflow set on drop", int'(ovf), 1);
    drain();
    chk(ovf === 1'b1, "R6 overflow sticky", int'(ovf), 1);

    // R10: resync mid-frame
    for (int s = 0; s < 5; s++) step(1, s == 0, 8'h00, 0);
    f[1] = 4'h2;
    frame(f, 3, -1);
    chk(exp_q.size() >= 1, "R10 resync event", exp_q.size(), 1);
    drain();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule